// File: doc/BRIEF.md
# Event Frame Timestamp Capture

This block sits beside the MAC and samples a free-running 64-bit nanosecond clock whenever a precision-timing event frame passes in either direction. Received frames are stamped into a small pool of capture slots. The pool has four slots by default. Transmitted frames go into a single dedicated slot. Once a slot captures a value, it holds it and refuses new captures until software reads the slot's high word. This read-to-release handshake is the only way a slot is freed. No write-to-clear exists.

For every received event strobe, the block returns a descriptor one cycle later. The descriptor tells the receive descriptor path whether the frame was stamped and, if so, which slot holds its stamp. Control inputs set the following:
- a global enable;
- the protocol version that is accepted;
- whether UDP-carried event messages may be stamped;
- whether a captured transmit stamp raises an interrupt.

A transmit stamp that arrives while the transmit slot is still held is lost. Each such loss is counted in a saturating counter.

Top module: `evt_stamp_unit`

## Requirements
- R1: After reset, every slot is free, the transmit status, the interrupt, the overflow count and the descriptor strobe are all zero, and both status words read as zero.
- R2: A receive event is stamped only when all of the following hold: the enable is set; the frame version (`rx_ver_i`) equals `ver_sel_i`, where 1 selects version 1 and 2 selects version 2; the message type is below 4 (an event message); and the frame is not UDP-carried unless `udp_en_i` is set. Any other receive event gets a descriptor with the valid flag low and index 0.
- R3: A stamped receive event stores the clock value sampled at the strobe edge into the lowest-numbered free slot. The descriptor appears in the next cycle with the valid flag high and that slot's index.
- R4: A latched slot keeps its value unchanged until it is released. Reading its low word does not release it.
- R5: Reading the high word of receive slot k releases that slot, and it can capture again from the following cycle.
- R6: When every receive slot is latched, a further receive event gets a descriptor with the valid flag low, and no held value changes.
- R7: A transmit event with the stamp request set, no segmentation offload and the enable set captures the clock into the transmit slot and sets `tx_stat_o` (status word bit 0).
- R8: A transmit event without the stamp request, or one flagged as segmentation offload, captures nothing.
- R9: A capturing transmit event that arrives while the transmit slot is latched is dropped, leaves the held value unchanged, and increments the overflow count, which saturates at its maximum.
- R10: `irq_o` is high exactly while the transmit status is set and `tx_irq_en_i` is high.
- R11: Reading status word 0 or the transmit high word releases the transmit slot and clears the transmit status.
- R12: The read port returns data one cycle after `rd_i`, with `rd_vld_o` high. The address map is:
  - 0: status word 0, bit 0 = transmit captured;
  - 1: status word 1, bit k = receive slot k latched;
  - 2 and 3: transmit low and high word;
  - 4+2k and 5+2k: receive slot k low and high word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| time_i | input | 64 | Running nanosecond clock |
| sync_en_i | input | 1 | Global stamping enable |
| ver_sel_i | input | 2 | Accepted protocol version (1 or 2) |
| udp_en_i | input | 1 | Allow stamping of UDP-carried events |
| tx_irq_en_i | input | 1 | Transmit stamp interrupt enable |
| tx_evt_i | input | 1 | Transmit event frame strobe |
| tx_req_i | input | 1 | Per-frame transmit stamp request |
| tx_seg_i | input | 1 | Frame uses segmentation offload |
| rx_evt_i | input | 1 | Receive frame strobe |
| rx_ver_i | input | 2 | Protocol version of received frame |
| rx_udp_i | input | 1 | Received frame is UDP-carried |
| rx_msg_i | input | 4 | Message type of received frame |
| rx_desc_vld_o | output | 1 | Descriptor strobe, one cycle after `rx_evt_i` |
| rx_desc_tsv_o | output | 1 | Frame was stamped |
| rx_desc_idx_o | output | 2 | Slot holding the stamp |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | 4 | Read address |
| rd_vld_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| rx_lat_o | output | 4 | Receive slot latched flags |
| tx_stat_o | output | 1 | Transmit stamp captured |
| tx_ovf_o | output | 8 | Dropped transmit stamp count |
| irq_o | output | 1 | Transmit stamp interrupt |

## Verification
The assertions assume the following about the inputs:
- A read and a capturing transmit event never fall in the same cycle. This keeps the drop count tied to a held slot.
- `time_i` advances every cycle, so a stable held value is distinct from a new capture.
- The address lies inside the map.

The stimulus drives each event and each read as an isolated one-cycle strobe, advances the clock model at every edge, and uses only mapped addresses. Slot occupancy is driven through free, partly filled, full and re-freed states. These states are reached in different orders, so both the lowest-free choice and the lockup are exercised.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int TIME_W      = 64;
  localparam int WORD_W      = 32;
  localparam int MSG_W       = 4;
  localparam int VER_W       = 2;
  localparam int EVT_MSG_LIM = 4;   // message types below this are event messages
  localparam int A_STAT0     = 0;
  localparam int A_STAT1     = 1;
  localparam int A_TX_LO     = 2;
  localparam int A_TX_HI     = 3;
  localparam int A_RX_BASE   = 4;
endpackage

// File: rtl/tsc_slot.sv
module tsc_slot #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         rel_i,
  input  logic [W-1:0] time_i,
  output logic         lat_o,
  output logic [W-1:0] val_o
);
  logic         lat_q;
  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 1'b0;
      val_q <= '0;
    end else if (cap_i && !lat_q) begin
      lat_q <= 1'b1;
      val_q <= time_i;
    end else if (rel_i) begin
      lat_q <= 1'b0;
    end
  end

  assign lat_o = lat_q;
  assign val_o = val_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q && !rel_i |=> lat_q && $stable(val_q));
endmodule

// File: rtl/tsc_rx_alloc.sv
module tsc_rx_alloc #(
  parameter  int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  busy_i,
  output logic [N-1:0]  gnt_o,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // scan downward so the lowest free slot is the last one assigned
  always_comb begin
    gnt_o   = '0;
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (!busy_i[k]) begin
        gnt_o    = '0;
        gnt_o[k] = 1'b1;
        found_o  = 1'b1;
        idx_o    = IW'(k);
      end
    end
  end
endmodule

// File: rtl/tsc_rd_mux.sv
module tsc_rd_mux
  import tsc_pkg::*;
#(
  parameter int N_RX   = 4,
  parameter int ADDR_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  input  logic                        tx_lat_i,
  input  logic [TIME_W-1:0]           tx_val_i,
  input  logic [N_RX-1:0]             rx_lat_i,
  input  logic [N_RX-1:0][TIME_W-1:0] rx_val_i,
  output logic                        rel_tx_o,
  output logic [N_RX-1:0]             rel_rx_o,
  output logic                        rd_vld_o,
  output logic [WORD_W-1:0]           rd_data_o
);
  logic [WORD_W-1:0] data_d;

  always_comb begin
    data_d   = '0;
    rel_tx_o = 1'b0;
    rel_rx_o = '0;
    if (rd_addr_i == ADDR_W'(A_STAT0)) begin
      data_d[0] = tx_lat_i;
      rel_tx_o  = rd_i;
    end
    if (rd_addr_i == ADDR_W'(A_STAT1)) data_d[N_RX-1:0] = rx_lat_i;
    if (rd_addr_i == ADDR_W'(A_TX_LO)) data_d = tx_val_i[WORD_W-1:0];
    if (rd_addr_i == ADDR_W'(A_TX_HI)) begin
      data_d   = tx_val_i[TIME_W-1:WORD_W];
      rel_tx_o = rd_i;
    end
    for (int k = 0; k < N_RX; k++) begin
      if (rd_addr_i == ADDR_W'(A_RX_BASE + 2 * k)) data_d = rx_val_i[k][WORD_W-1:0];
      if (rd_addr_i == ADDR_W'(A_RX_BASE + 2 * k + 1)) begin
        data_d      = rx_val_i[k][TIME_W-1:WORD_W];
        rel_rx_o[k] = rd_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_vld_o <= rd_i;
      if (rd_i) rd_data_o <= data_d;
    end
  end

  assert_rd_lat_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rd_vld_o);
endmodule

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit
  import tsc_pkg::*;
#(
  parameter  int N_RX   = 4,
  parameter  int OVF_W  = 8,
  parameter  int ADDR_W = 4,
  localparam int IDX_W  = $clog2(N_RX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              sync_en_i,
  input  logic [VER_W-1:0]  ver_sel_i,
  input  logic              udp_en_i,
  input  logic              tx_irq_en_i,
  input  logic              tx_evt_i,
  input  logic              tx_req_i,
  input  logic              tx_seg_i,
  input  logic              rx_evt_i,
  input  logic [VER_W-1:0]  rx_ver_i,
  input  logic              rx_udp_i,
  input  logic [MSG_W-1:0]  rx_msg_i,
  output logic              rx_desc_vld_o,
  output logic              rx_desc_tsv_o,
  output logic [IDX_W-1:0]  rx_desc_idx_o,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_vld_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [N_RX-1:0]   rx_lat_o,
  output logic              tx_stat_o,
  output logic [OVF_W-1:0]  tx_ovf_o,
  output logic              irq_o
);
  logic                        rx_hit, rx_found;
  logic [N_RX-1:0]             rx_gnt, rx_cap, rx_rel, rx_lat;
  logic [IDX_W-1:0]            rx_idx;
  logic [N_RX-1:0][TIME_W-1:0] rx_val;
  logic                        tx_fire, tx_lat, tx_rel;
  logic [TIME_W-1:0]           tx_val;
  logic [OVF_W-1:0]            ovf_q;

  assign rx_hit = rx_evt_i && sync_en_i && (rx_ver_i == ver_sel_i) &&
                  (rx_msg_i < MSG_W'(EVT_MSG_LIM)) && (!rx_udp_i || udp_en_i);

  tsc_rx_alloc #(.N(N_RX)) u_alloc (
    .busy_i (rx_lat),
    .gnt_o  (rx_gnt),
    .found_o(rx_found),
    .idx_o  (rx_idx)
  );

  assign rx_cap = rx_gnt & {N_RX{rx_hit}};

  for (genvar g = 0; g < N_RX; g++) begin : g_rx_slot
    tsc_slot #(.W(TIME_W)) u_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cap_i (rx_cap[g]),
      .rel_i (rx_rel[g]),
      .time_i(time_i),
      .lat_o (rx_lat[g]),
      .val_o (rx_val[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_desc_vld_o <= 1'b0;
      rx_desc_tsv_o <= 1'b0;
      rx_desc_idx_o <= '0;
    end else begin
      rx_desc_vld_o <= rx_evt_i;
      rx_desc_tsv_o <= rx_hit && rx_found;
      rx_desc_idx_o <= (rx_hit && rx_found) ? rx_idx : '0;
    end
  end

  assign tx_fire = tx_evt_i && tx_req_i && !tx_seg_i && sync_en_i;

  tsc_slot #(.W(TIME_W)) u_tx_slot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (tx_fire),
    .rel_i (tx_rel),
    .time_i(time_i),
    .lat_o (tx_lat),
    .val_o (tx_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= '0;
    else if (tx_fire && tx_lat && (ovf_q != {OVF_W{1'b1}})) ovf_q <= ovf_q + 1'b1;
  end

  tsc_rd_mux #(.N_RX(N_RX), .ADDR_W(ADDR_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_i),
    .rd_addr_i(rd_addr_i),
    .tx_lat_i (tx_lat),
    .tx_val_i (tx_val),
    .rx_lat_i (rx_lat),
    .rx_val_i (rx_val),
    .rel_tx_o (tx_rel),
    .rel_rx_o (rx_rel),
    .rd_vld_o (rd_vld_o),
    .rd_data_o(rd_data_o)
  );

  assign rx_lat_o  = rx_lat;
  assign tx_stat_o = tx_lat;
  assign tx_ovf_o  = ovf_q;
  assign irq_o     = tx_lat && tx_irq_en_i;

  assert_desc_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_desc_vld_o && rx_desc_tsv_o |-> rx_lat_o[rx_desc_idx_o]);
  assert_full_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_desc_vld_o && $past(&rx_lat_o) |-> !rx_desc_tsv_o);
  assert_ovf_sat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_o == {OVF_W{1'b1}} |=> tx_ovf_o == {OVF_W{1'b1}});
  assert_tx_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_stat_o) |-> $past(tx_evt_i && tx_req_i));
endmodule

// File: tb/evt_stamp_unit_bench.sv
`timescale 1ns/1ps
module evt_stamp_unit_bench;
  localparam int NRX = 4;
  localparam int OVW = 8;
  localparam int OVMAX = (1 << OVW) - 1;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [63:0] tb_time = 64'h0000_0003_FFFF_FF00;
  logic        sync_en = 0, udp_en = 0, irq_en = 0;
  logic [1:0]  ver_sel = 2'd2;
  logic        tx_evt = 0, tx_req = 0, tx_seg = 0;
  logic        rx_evt = 0, rx_udp = 0;
  logic [1:0]  rx_ver = 0;
  logic [3:0]  rx_msg = 0;
  logic        rx_desc_vld, rx_desc_tsv;
  logic [1:0]  rx_desc_idx;
  logic        rd = 0, rd_vld;
  logic [3:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic [NRX-1:0] rx_lat;
  logic        tx_stat, irq;
  logic [OVW-1:0] tx_ovf;

  evt_stamp_unit u_evt_stamp_unit (
    .clk_i(clk), .rst_ni(rst_ni), .time_i(tb_time), .sync_en_i(sync_en),
    .ver_sel_i(ver_sel), .udp_en_i(udp_en), .tx_irq_en_i(irq_en),
    .tx_evt_i(tx_evt), .tx_req_i(tx_req), .tx_seg_i(tx_seg),
    .rx_evt_i(rx_evt), .rx_ver_i(rx_ver), .rx_udp_i(rx_udp), .rx_msg_i(rx_msg),
    .rx_desc_vld_o(rx_desc_vld), .rx_desc_tsv_o(rx_desc_tsv), .rx_desc_idx_o(rx_desc_idx),
    .rd_i(rd), .rd_addr_i(rd_addr), .rd_vld_o(rd_vld), .rd_data_o(rd_data),
    .rx_lat_o(rx_lat), .tx_stat_o(tx_stat), .tx_ovf_o(tx_ovf), .irq_o(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) tb_time <= tb_time + 64'd3;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  bit [NRX-1:0] m_rx_lat = '0;
  logic [63:0]  m_rx_val [NRX];
  bit           m_tx_lat = 0;
  logic [63:0]  m_tx_val = '0;
  int           m_ovf = 0;

  logic [2:0]  dsc_q[$];
  string       dtag_q[$];
  logic [31:0] rdq[$];
  string       rtag_q[$];

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic rx_frame(logic [1:0] v, logic u, logic [3:0] m, string r);
    bit acc = sync_en && (v == ver_sel) && (m < 4) && (!u || udp_en);
    int slot = -1;
    for (int k = NRX - 1; k >= 0; k--) if (!m_rx_lat[k]) slot = k;
    if (acc && slot >= 0) begin
      m_rx_lat[slot] = 1'b1;
      m_rx_val[slot] = tb_time;
      dsc_q.push_back({1'b1, 2'(slot)});
    end else begin
      dsc_q.push_back(3'b000);
    end
    dtag_q.push_back(r);
    rx_evt = 1; rx_ver = v; rx_udp = u; rx_msg = m;
    @(negedge clk);
    rx_evt = 0;
  endtask

  task automatic tx_frame(logic q, logic s);
    if (sync_en && q && !s) begin
      if (m_tx_lat) begin
        if (m_ovf < OVMAX) m_ovf++;
      end else begin
        m_tx_lat = 1;
        m_tx_val = tb_time;
      end
    end
    tx_evt = 1; tx_req = q; tx_seg = s;
    @(negedge clk);
    tx_evt = 0;
  endtask

  task automatic rd_word(int a, string r);
    logic [31:0] e = '0;
    if (a == 0) begin e[0] = m_tx_lat; m_tx_lat = 0; end
    else if (a == 1) e[NRX-1:0] = m_rx_lat;
    else if (a == 2) e = m_tx_val[31:0];
    else if (a == 3) begin e = m_tx_val[63:32]; m_tx_lat = 0; end
    else begin
      int k = (a - 4) / 2;
      if (a % 2 == 0) e = m_rx_val[k][31:0];
      else begin e = m_rx_val[k][63:32]; m_rx_lat[k] = 0; end
    end
    rdq.push_back(e);
    rtag_q.push_back(r);
    rd = 1; rd_addr = 4'(a);
    @(negedge clk);
    rd = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && rx_desc_vld) begin
      if (dsc_q.size() == 0) chk("R3 unexpected descriptor", 1, 0);
      else chk(dtag_q.pop_front(), {rx_desc_tsv, rx_desc_idx}, dsc_q.pop_front());
    end
    if (rst_ni && rd_vld) begin
      if (rdq.size() == 0) chk("R12 unexpected read data", 1, 0);
      else chk(rtag_q.pop_front(), rd_data, rdq.pop_front());
    end
  end

  task automatic chk_tx(string r);
    chk({r, " stat"}, tx_stat, m_tx_lat);
    chk({r, " irq R10"}, irq, m_tx_lat && irq_en);
    chk({r, " ovf"}, tx_ovf, m_ovf);
  endtask

  initial begin
    for (int k = 0; k < NRX; k++) m_rx_val[k] = '0;
    repeat (3) @(negedge clk);
    chk("R1 rx_lat", rx_lat, 0);
    chk("R1 desc", rx_desc_vld, 0);
    chk_tx("R1");
    rst_ni = 1;
    @(negedge clk);
    rd_word(0, "R1 stat0");
    rd_word(1, "R1 stat1");

    sync_en = 1; ver_sel = 2; udp_en = 0;
    rx_frame(2, 0, 0, "R3 first to slot0");
    rx_frame(2, 0, 1, "R3 next to slot1");
    rx_frame(2, 0, 5, "R2 non-event type");
    rx_frame(1, 0, 0, "R2 wrong version");
    rx_frame(2, 1, 2, "R2 udp blocked");
    udp_en = 1;
    rx_frame(2, 1, 2, "R2 udp allowed slot2");
    sync_en = 0;
    rx_frame(2, 0, 0, "R2 disabled");
    sync_en = 1;
    chk("R3 latched flags", rx_lat, 4'b0111);

    rd_word(4, "R4 slot0 lo");
    rd_word(1, "R4 stat1 after lo read");
    rd_word(7, "R5 slot1 hi");
    @(negedge clk);
    chk("R5 slot1 free", rx_lat, 4'b0101);
    rx_frame(2, 0, 3, "R5 reuse slot1");
    rx_frame(2, 0, 0, "R3 fill slot3");
    chk("R6 all latched", rx_lat, 4'b1111);
    rx_frame(2, 0, 0, "R6 full lockup");
    rx_frame(2, 0, 1, "R6 full lockup again");
    for (int a = 4; a < 12; a += 2) rd_word(a, "R6 values held");
    rd_word(9, "R5 slot2 hi");
    rx_frame(2, 0, 2, "R5 refill slot2");
    rd_word(8, "R4 slot2 lo new");
    rd_word(1, "R12 stat1");

    irq_en = 0;
    tx_frame(1, 1); chk_tx("R8 seg frame");
    tx_frame(0, 0); chk_tx("R8 no request");
    tx_frame(1, 0); chk_tx("R7 capture");
    irq_en = 1;
    #1 chk_tx("R10 irq enabled");
    @(negedge clk);
    tx_frame(1, 0); chk_tx("R9 drop");
    rd_word(2, "R9 tx lo held");
    rd_word(3, "R11 tx hi");
    @(negedge clk); chk_tx("R11 released by hi");
    tx_frame(1, 0); chk_tx("R7 recapture");
    rd_word(0, "R11 stat0");
    @(negedge clk); chk_tx("R11 released by stat0");
    tx_frame(1, 0);
    for (int i = 0; i < 300; i++) tx_frame(1, 0);
    chk_tx("R9 saturate");
    chk("R9 count max", tx_ovf, OVMAX);

    for (int k = 0; k < NRX; k++) rd_word(5 + 2 * k, "R5 free all");
    ver_sel = 1;
    rx_frame(2, 0, 0, "R2 v2 rejected in v1 mode");
    rx_frame(1, 0, 1, "R2 v1 accepted slot0");
    rd_word(4, "R3 v1 stamp lo");

    repeat (4) @(negedge clk);
    chk("R12 queues drained", dsc_q.size() + rdq.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule